// File: doc/BRIEF.md
# 32-Pin GPIO Port with Set/Clear Control

This block is a general-purpose I/O port of 32 pins attached to a small APB-style register bus. Software never writes the direction or the output value of a pin directly. It writes a mask word to a "set" address or a "clear" address, and only the pins whose mask bit is 1 change. A read-only data address returns the synchronized level of every pin.

Two plain read/write selector registers, one bit per pin, pick the pin's function. The pair of bits forms a 2-bit code that goes to the pad ring. Whenever a pin is given to an alternate function, the GPIO output enable for that pin is forced off, so the peripheral owns the pad. The pad side is modelled as separate output, output-enable and input vectors, plus the per-pin function code.

The bus uses two phases and has no wait states. Read data is captured in the setup cycle and is valid throughout the access cycle. Writes take effect at the clock edge that ends the access cycle.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, and after it is released, every pin is an input, the output latch is 0, both selector registers are 0, and `pad_oe`, `pad_out` and `pad_fn` are all 0.
- R2: A write to byte address 0x0C (direction set) makes each pin whose data bit is 1 an output. Pins whose bit is 0 keep their direction.
- R3: A write to byte address 0x10 (direction clear) makes each pin whose data bit is 1 an input. Pins whose bit is 0 keep their direction.
- R4: A write to byte address 0x04 drives the output latch high for each pin whose bit is 1. A write to 0x08 drives it low for each pin whose bit is 1. Zero bits have no effect. The latch appears on `pad_out`.
- R5: A read of byte address 0x00 returns the pin levels after a two-flop synchronizer. A level applied just before a read's setup cycle is not yet visible in that read; it is visible in the next read. Writes to 0x00 change nothing.
- R6: Selector A (byte address 0x14) and selector B (byte address 0x18) are 32-bit read/write registers, and bit n of each belongs to pin n.
- R7: `pad_fn[2n+1:2n]` equals {B bit n, A bit n}. The code 00 is GPIO, 01 is alternate A, 10 is alternate B and 11 is the third alternate.
- R8: `pad_oe[n]` is 1 only when pin n is an output and its function code is 00. `pad_out` still shows the latch in the alternate modes.
- R9: Reads of 0x04 and 0x08 return the output latch. Reads of 0x0C and 0x10 return the direction register. A read of the unmapped address 0x1C returns 0.
- R10: A register changes only on a completed write, that is, a write with `psel`, `penable` and `pwrite` all high. A setup cycle without an access cycle leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output latch to the pads |
| pad_oe | output | 32 | Output enable to the pads |
| pad_fn | output | 64 | Per-pin function code {B,A} |

## Verification
The bench sends random masks to all four set/clear addresses against a model.

- A design that writes the register directly, instead of OR-ing or AND-NOT-ing the mask into it, disturbs pins whose mask bit is 0.
- A design that drops the output-enable masking drives the pad in an alternate mode.
- Swapped selector bits give a wrong code on `pad_fn`.

Directed cases cover:

- The synchronizer latency: one stage too few shows the new level one read early.
- Writes to the data address.
- An abandoned setup cycle: a design that commits on `psel` alone changes state there.
- The unmapped address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GP_PINS = 32;
  localparam int GP_ADDR_W = 5;
  // word index of each register (byte address / 4)
  localparam logic [2:0] IX_LEVEL   = 3'd0;
  localparam logic [2:0] IX_OUT_SET = 3'd1;
  localparam logic [2:0] IX_OUT_CLR = 3'd2;
  localparam logic [2:0] IX_DIR_SET = 3'd3;
  localparam logic [2:0] IX_DIR_CLR = 3'd4;
  localparam logic [2:0] IX_SEL_A   = 3'd5;
  localparam logic [2:0] IX_SEL_B   = 3'd6;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate
  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int N = 32
) (
  input  logic [N-1:0]   dir,
  input  logic [N-1:0]   sel_a,
  input  logic [N-1:0]   sel_b,
  output logic [N-1:0]   oe,
  output logic [2*N-1:0] fn
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      logic [1:0] code;
      assign code = {sel_b[i], sel_a[i]};
      assign fn[2*i+1:2*i] = code;
      assign oe[i] = dir[i] & (code == 2'b00);
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int N = gpio_pkg::GP_PINS,
  parameter int ADDR_W = gpio_pkg::GP_ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N-1:0]    pwdata,
  output logic [N-1:0]    prdata,
  output logic            pready,
  input  logic [N-1:0]    pad_in,
  output logic [N-1:0]    pad_out,
  output logic [N-1:0]    pad_oe,
  output logic [2*N-1:0]  pad_fn
);
  import gpio_pkg::*;
  localparam int IX_W = ADDR_W - 2;

  logic [IX_W-1:0] ix;
  logic            wr_acc, rd_setup;
  logic [N-1:0]    dir_q, out_q, sel_a_q, sel_b_q, lvl_q;
  logic [N-1:0]    rd_mux;

  assign ix       = paddr[ADDR_W-1:2];
  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign pready   = 1'b1;

  function automatic logic hit(input logic [IX_W-1:0] a, input logic [2:0] k);
    return a == IX_W'(k);
  endfunction

  gpio_setclr_reg #(.W(N)) u_dir (
    .clk(clk), .rst(rst),
    .set_en(wr_acc & hit(ix, IX_DIR_SET)),
    .clr_en(wr_acc & hit(ix, IX_DIR_CLR)),
    .mask(pwdata), .q(dir_q));

  gpio_setclr_reg #(.W(N)) u_out (
    .clk(clk), .rst(rst),
    .set_en(wr_acc & hit(ix, IX_OUT_SET)),
    .clr_en(wr_acc & hit(ix, IX_OUT_CLR)),
    .mask(pwdata), .q(out_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_a_q <= '0;
      sel_b_q <= '0;
    end else if (wr_acc) begin
      if (hit(ix, IX_SEL_A)) sel_a_q <= pwdata;
      if (hit(ix, IX_SEL_B)) sel_b_q <= pwdata;
    end
  end

  gpio_in_sync #(.W(N), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_q));

  gpio_pad_mux #(.N(N)) u_mux (
    .dir(dir_q), .sel_a(sel_a_q), .sel_b(sel_b_q),
    .oe(pad_oe), .fn(pad_fn));

  assign pad_out = out_q;

  always_comb begin
    rd_mux = '0;
    if (hit(ix, IX_LEVEL))                          rd_mux = lvl_q;
    if (hit(ix, IX_OUT_SET) || hit(ix, IX_OUT_CLR)) rd_mux = out_q;
    if (hit(ix, IX_DIR_SET) || hit(ix, IX_DIR_CLR)) rd_mux = dir_q;
    if (hit(ix, IX_SEL_A))                          rd_mux = sel_a_q;
    if (hit(ix, IX_SEL_B))                          rd_mux = sel_b_q;
  end

  // read data is captured in the setup cycle and held through the access cycle
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [N-1:0]      pwdata,
  input logic [N-1:0]      dir_q,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_oe,
  input logic [2*N-1:0]    pad_fn
);
  logic wr;
  logic [ADDR_W-3:0] wix;
  assign wr  = psel & penable & pwrite;
  assign wix = paddr[ADDR_W-1:2];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && pad_fn == '0 && dir_q == '0));

  assert_dir_set_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && wix == 3) |=> ((dir_q & $past(pwdata)) == $past(pwdata)) &&
      ((dir_q & ~$past(pwdata)) == ($past(dir_q) & ~$past(pwdata))));

  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && wix == 4) |=> ((dir_q & $past(pwdata)) == '0) &&
      ((dir_q & ~$past(pwdata)) == ($past(dir_q) & ~$past(pwdata))));

  assert_out_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && wix == 1) |=> ((pad_out & $past(pwdata)) == $past(pwdata)));

  assert_out_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && wix == 2) |=> ((pad_out & $past(pwdata)) == '0));

  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr && (wix == 3 || wix == 4)) |=> $stable(dir_q));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr && (wix == 1 || wix == 2)) |=> $stable(pad_out));

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_mask
      assert_oe_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (pad_fn[2*i+1:2*i] != 2'b00) |-> !pad_oe[i]);
    end
  endgenerate
endmodule

bind gpio_port gpio_port_chk #(.N(N), .ADDR_W(ADDR_W)) u_gpio_port_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .dir_q(dir_q), .pad_out(pad_out),
  .pad_oe(pad_oe), .pad_fn(pad_fn));

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int N = 32;
  logic clk = 0, rst = 1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0] paddr = '0;
  logic [N-1:0] pwdata = '0, prdata, pad_in = '0, pad_out, pad_oe;
  logic [2*N-1:0] pad_fn;
  logic pready;
  int checks = 0, errors = 0;
  logic [N-1:0] m_dir = '0, m_out = '0, m_a = '0, m_b = '0, m_lvl = '0;

  always #2 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_fn(pad_fn));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] exp_fn(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [2*N-1:0] f;
    for (int i = 0; i < N; i++) f[2*i +: 2] = {b[i], a[i]};
    return f;
  endfunction

  function automatic logic [N-1:0] exp_rd(input int ix);
    case (ix)
      0: return m_lvl;
      1, 2: return m_out;
      3, 4: return m_dir;
      5: return m_a;
      6: return m_b;
      default: return '0;
    endcase
  endfunction

  task automatic bus(input logic w, input int ix, input logic [N-1:0] d, output logic [N-1:0] rd);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = 5'(ix * 4); pwdata = d;
    @(negedge clk);
    penable = 1;
    rd = prdata;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input int ix, input logic [N-1:0] d);
    logic [N-1:0] rd;
    bus(1'b1, ix, d, rd);
    case (ix)
      1: m_out |= d;
      2: m_out &= ~d;
      3: m_dir |= d;
      4: m_dir &= ~d;
      5: m_a = d;
      6: m_b = d;
      default: ;
    endcase
  endtask

  task automatic check_pads(input string tag);
    chk({tag, " R4 pad_out"}, 64'(pad_out), 64'(m_out));
    chk({tag, " R8 pad_oe"}, 64'(pad_oe), 64'(m_dir & ~(m_a | m_b)));
    chk({tag, " R7 pad_fn"}, pad_fn, exp_fn(m_a, m_b));
  endtask

  task automatic rd_chk(input string tag, input int ix);
    logic [N-1:0] rd;
    bus(1'b0, ix, '0, rd);
    chk(tag, 64'(rd), 64'(exp_rd(ix)));
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] rd;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    check_pads("R1 during reset");
    rst = 0;
    @(negedge clk);
    check_pads("R1 after reset");
    for (int k = 0; k < 7; k++) rd_chk("R1 reset read", k);

    // directed: set/clear leave zero bits alone
    wr(3, 32'h0000_FFFF); check_pads("R2 dir set");
    wr(3, 32'hFF00_0000); check_pads("R2 dir set merge");
    wr(4, 32'h0000_0F0F); check_pads("R3 dir clear");
    wr(1, 32'hA5A5_A5A5); check_pads("R4 out set");
    wr(2, 32'h0000_00FF); check_pads("R4 out clear");
    rd_chk("R9 read out via set addr", 1);
    rd_chk("R9 read out via clr addr", 2);
    rd_chk("R9 read dir via set addr", 3);
    rd_chk("R9 read dir via clr addr", 4);
    rd_chk("R9 unmapped read", 7);

    // function codes: all four per pin
    wr(5, 32'h0000_00F0); wr(6, 32'h0000_00CC);
    check_pads("R7 codes");
    rd_chk("R6 sel A read", 5);
    rd_chk("R6 sel B read", 6);

    // R5 synchronizer latency
    @(negedge clk); pad_in = 32'h1234_5678;
    bus(1'b0, 0, '0, rd);
    chk("R5 level not yet visible", 64'(rd), 64'(m_lvl));
    m_lvl = 32'h1234_5678;
    rd_chk("R5 level visible", 0);
    wr(0, 32'hFFFF_FFFF);
    check_pads("R5 data write ignored");
    rd_chk("R5 data write ignored read", 0);

    // R10 abandoned setup cycle
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = 5'h0C; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    psel = 0; pwrite = 0;
    @(negedge clk);
    check_pads("R10 setup only");
    rd_chk("R10 dir unchanged", 3);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 7));
      if (op == 0) begin
        pad_in = $urandom;
        m_lvl = pad_in;
        repeat (3) @(negedge clk);
        rd_chk("R5 random level", 0);
      end else if (op == 7) begin
        rd_chk("R9 random read", int'($urandom_range(1, 7)));
      end else begin
        wr(op, $urandom);
        check_pads("R2 R3 R4 R6 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule